// File: doc/BRIEF.md
# Dual-Lane Bidirectional Bus Transceiver with Parity

The block joins two buses, side A and side B, through independent byte lanes. Each lane has its own controls: a direction select, a high-impedance control and a parity-sense select. Each lane also has a parity pin that changes direction with the data. When a lane moves data from A to B, the lane computes the parity bit from the A byte and drives it on the parity pin. When a lane moves data from B to A, it reads the parity pin as an input and checks that pin and the B byte against the selected sense. It reports the result on an active-low error flag.

The block is purely combinational and has no clock. Each bidirectional pin is a resolved inout. The block also reports a drive-enable per port, so a surrounding design or a bench can see which side owns each wire.

Top module: `xcvr_parity`

## Requirements
- R1: With a lane enabled and its direction bit at 1 (transmit), the B byte of that lane equals its A byte.
- R2: With a lane enabled and its direction bit at 0 (receive), the A byte of that lane equals its B byte.
- R3: With a lane's hiz bit at 1, the block drives none of the A, B and parity pins of that lane, and the lane's err_n reads 1.
- R4: In transmit, the lane drives a parity bit that makes the count of ones over its 8 A bits plus that bit even when odd_sel is 0 and odd when odd_sel is 1. For example, five ones with odd_sel 0 give parity 1.
- R5: In receive, err_n is 0 exactly when the count of ones over the 8 B bits plus the received parity bit disagrees with the selected sense (even for odd_sel 0, odd for odd_sel 1). For example, odd_sel 1, parity 1 and three ones on B give err_n 0.
- R6: In transmit, err_n is held at 1.
- R7: The parity pin of a lane is driven by the block only when that lane is enabled and transmitting. In receive, the lane leaves the pin free and does not use its B-side pins as an input to anything while transmitting.
- R8: Lane 0 uses bits 7:0 of the A and B buses and lane 1 uses bits 15:8. Index i of dir, hiz, odd_sel, par_io, err_n and of each drive enable belongs to lane i. The lanes are independent of each other.
- R9: The drive-enable outputs report ownership: b_drv and par_drv are 1 exactly in enabled transmit, a_drv is 1 exactly in enabled receive, and a_drv and b_drv are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir | input | 2 | Per lane: 1 drives A to B (transmit), 0 drives B to A (receive) |
| hiz | input | 2 | Per lane: 1 releases all of the lane's pins |
| odd_sel | input | 2 | Per lane: 1 selects odd parity, 0 selects even |
| a_io | inout | 16 | Side A data, lane i in bits 8i+7:8i |
| b_io | inout | 16 | Side B data, lane i in bits 8i+7:8i |
| par_io | inout | 2 | Per lane parity pin: output in transmit, input in receive |
| err_n | output | 2 | Per lane parity error, active low |
| a_drv | output | 2 | Per lane: block is driving the A byte |
| b_drv | output | 2 | Per lane: block is driving the B byte |
| par_drv | output | 2 | Per lane: block is driving the parity pin |

## Verification
The bench runs each lane through every byte value under both parity senses and both directions, with both values of the received parity bit. The other lane runs at the same time in the opposite direction and sense, so crossed lane wiring shows up as wrong data or parity on the wrong byte. An inverted sense select would flip every generated parity bit. A checker that counted only the data bits would flag half of the clean receives. Further vectors drive every pin from outside with the lanes released. If the block still drove any pin or showed an error there, the pin levels and drive enables would differ from the values the bench forced.

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int LANES = 2,
  parameter int W     = 8
) (
  input  logic [LANES-1:0]   dir,
  input  logic [LANES-1:0]   hiz,
  input  logic [LANES-1:0]   odd_sel,
  inout  wire  [LANES*W-1:0] a_io,
  inout  wire  [LANES*W-1:0] b_io,
  inout  wire  [LANES-1:0]   par_io,
  output logic [LANES-1:0]   err_n,
  output logic [LANES-1:0]   a_drv,
  output logic [LANES-1:0]   b_drv,
  output logic [LANES-1:0]   par_drv
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] a_in, b_in;
    logic         live, p_gen, rx_ok;

    assign a_in  = a_io[i*W +: W];
    assign b_in  = b_io[i*W +: W];
    assign live  = ~hiz[i];

    assign a_drv[i]   = live & ~dir[i];
    assign b_drv[i]   = live &  dir[i];
    assign par_drv[i] = live &  dir[i];

    assign p_gen = (^a_in) ^ odd_sel[i];
    assign rx_ok = ((^b_in) ^ par_io[i]) == odd_sel[i];
    assign err_n[i] = hiz[i] | dir[i] | rx_ok;

    for (genvar k = 0; k < W; k++) begin : g_bit
      assign a_io[i*W+k] = a_drv[i] ? b_in[k] : 1'bz;
      assign b_io[i*W+k] = b_drv[i] ? a_in[k] : 1'bz;
    end
    assign par_io[i] = par_drv[i] ? p_gen : 1'bz;
  end
endmodule

// File: rtl/xcvr_parity_chk.sv
module xcvr_parity_chk #(
  parameter int LANES = 2,
  parameter int W     = 8
) (
  input logic [LANES-1:0]   dir,
  input logic [LANES-1:0]   hiz,
  input logic [LANES-1:0]   odd_sel,
  input logic [LANES*W-1:0] a_io,
  input logic [LANES*W-1:0] b_io,
  input logic [LANES-1:0]   par_io,
  input logic [LANES-1:0]   err_n,
  input logic [LANES-1:0]   a_drv,
  input logic [LANES-1:0]   b_drv,
  input logic [LANES-1:0]   par_drv
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      AST_HIZ_QUIET: assert (!hiz[i] || (!a_drv[i] && !b_drv[i] && !par_drv[i] && err_n[i])); // R3
      AST_ONE_SIDE: assert (!(a_drv[i] && b_drv[i])); // R9
      AST_PAR_ONLY_TX: assert (!par_drv[i] || dir[i]); // R7
      AST_TX_NO_ERR: assert (!(dir[i] && !hiz[i]) || err_n[i]); // R6
      AST_TX_COPY: assert (!b_drv[i] || b_io[i*W +: W] == a_io[i*W +: W]); // R1
      AST_TX_SENSE: assert (!par_drv[i] || (($countones(a_io[i*W +: W]) + int'(par_io[i])) % 2) == int'(odd_sel[i])); // R4
    end
  end
endmodule

bind xcvr_parity xcvr_parity_chk #(.LANES(LANES), .W(W)) u_chk (.*);

// File: tb/tb_xcvr_parity.sv
module tb_xcvr_parity;
  localparam int L = 2;
  localparam int W = 8;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [L-1:0] dir, hiz, odd_sel;
  logic [L-1:0] err_n, a_drv, b_drv, par_drv;
  wire  [L*W-1:0] a_io, b_io;
  wire  [L-1:0]   par_io;
  logic [L*W-1:0] a_val = '0, a_en = '0, b_val = '0, b_en = '0;
  logic [L-1:0]   p_val = '0, p_en = '0;

  for (genvar k = 0; k < L*W; k++) begin : g_drv
    assign a_io[k] = a_en[k] ? a_val[k] : 1'bz;
    assign b_io[k] = b_en[k] ? b_val[k] : 1'bz;
  end
  for (genvar k = 0; k < L; k++) begin : g_pdrv
    assign par_io[k] = p_en[k] ? p_val[k] : 1'bz;
  end

  xcvr_parity #(.LANES(L), .W(W)) dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int k = 0; k < W; k++) if (v[k]) n++;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic setup(input int ln, input bit d, input bit z, input bit o,
                       input logic [W-1:0] v, input bit p);
    dir[ln] = d; hiz[ln] = z; odd_sel[ln] = o;
    a_val[ln*W +: W] = v; b_val[ln*W +: W] = v; p_val[ln] = p;
    a_en[ln*W +: W] = (z || d) ? '1 : '0;
    b_en[ln*W +: W] = (z || !d) ? '1 : '0;
    p_en[ln] = z || !d;
  endtask

  task automatic verify(input int ln, input bit d, input bit z, input bit o,
                        input logic [W-1:0] v, input bit p);
    int sense;
    if (z) begin
      chk("R3 drives", {a_drv[ln], b_drv[ln], par_drv[ln]}, 0);
      chk("R3 err_n", err_n[ln], 1);
      chk("R3 pins", {a_io[ln*W +: W], b_io[ln*W +: W], par_io[ln]}, {v, v, p});
    end else if (d) begin
      chk("R1 B byte", b_io[ln*W +: W], v);
      chk("R4 parity", par_io[ln], ((ones(v) % 2) != int'(o)) ? 1 : 0);
      chk("R6 err_n tx", err_n[ln], 1);
      chk("R9/R7 tx drives", {a_drv[ln], b_drv[ln], par_drv[ln]}, 3'b011);
    end else begin
      sense = (ones(v) + int'(p)) % 2;
      chk("R2 A byte", a_io[ln*W +: W], v);
      chk("R5 err_n rx", err_n[ln], (sense == int'(o)) ? 1 : 0);
      chk("R9/R7 rx drives", {a_drv[ln], b_drv[ln], par_drv[ln]}, 3'b100);
      chk("R7 par pin", par_io[ln], p);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    dir = '0; hiz = '1; odd_sel = '0;
    for (int ln = 0; ln < L; ln++) setup(ln, 0, 1, 0, 8'h00, 0);
    @(posedge clk); #1;
    @(negedge clk);
    for (int ln = 0; ln < L; ln++) verify(ln, 0, 1, 0, 8'h00, 0);
    // R5 worked example: odd, parity 1, three ones -> error
    @(posedge clk); #1;
    setup(0, 0, 0, 1, 8'b0000_0111, 1); setup(1, 1, 0, 0, 8'b0001_1111, 0);
    @(negedge clk);
    chk("R5 example", err_n[0], 0);
    chk("R4 example", par_io[1], 1);
    // R8 full sweep, lanes in opposite modes
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 2; o++)
        for (int p = 0; p < 2; p++)
          for (int v = 0; v < 256; v++) begin
            @(posedge clk); #1;
            setup(0, d[0], 0, o[0], v[7:0], p[0]);
            setup(1, !d[0], 0, !o[0], ~v[7:0], p[0]);
            @(negedge clk);
            verify(0, d[0], 0, o[0], v[7:0], p[0]);
            verify(1, !d[0], 0, !o[0], ~v[7:0], p[0]);
          end
    // R3 release on one lane while the other works
    for (int v = 0; v < 256; v += 37) begin
      @(posedge clk); #1;
      setup(0, v[0], 1, v[1], v[7:0], v[2]);
      setup(1, 0, 0, 1, v[7:0], 1);
      @(negedge clk);
      verify(0, v[0], 1, v[1], v[7:0], v[2]);
      verify(1, 0, 0, 1, v[7:0], 1);
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule